// File: doc/BRIEF.md
# Cascadable Display-Driver Serial Write Receiver

This block is the receive front end of a segment-display driver that sits, together with up to fifteen siblings, on one two-wire I2C bus. It oversamples the clock and data lines with the system clock, recognises START and STOP conditions, and checks the first byte of each transfer against a fixed 6-bit stem extended by one strap pin. A transfer that matches and asks for a write is accepted. Any other transfer is ignored until the next START.

After the address, the block reads a run of command bytes. The top bit of each command byte says whether another command follows. Every command byte leaves the block as a one-cycle strobe carrying its seven low bits. Two command forms are also decoded here: one loads the display-RAM pointer and the other loads the bank counter. All bytes after the last command are display data. Every address-matched device moves its pointer and bank counter forward after each data byte. Only the device whose 3-bit hardware identity equals the bank counter acknowledges the byte and writes it into its display RAM.

Top module: `lcdrx_top`

## Requirements
- R1: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) puts the parser back into the address phase. A repeated START without a STOP restarts address matching.
- R2: The address byte is acknowledged only when its bits 7..2 are 011111, its bit 1 equals `bus_sel_i` and its bit 0 (read/write) is 0. On any other address byte the device does not acknowledge, does not strobe, does not write and does not drive SDA until the next START.
- R3: Every command byte is acknowledged by every address-matched device, whatever `dev_id_i` holds. Each command byte produces exactly one `cmd_valid_o` pulse of one cycle, with `cmd_o` equal to the byte's bits 6..0.
- R4: Bit 7 of a command byte set to 1 means another command byte follows. Bit 7 cleared marks the last command, and every later byte of the transfer is display data.
- R5: A data byte is acknowledged, and written with one `ram_we_o` pulse at `ram_addr_o` equal to the current pointer, only when the bank counter equals `dev_id_i`. Otherwise it is neither acknowledged nor written.
- R6: After each data byte, every matched device increments the 6-bit pointer, whether or not it wrote the byte. When the pointer wraps from 63 to 0, the bank counter increments modulo 8.
- R7: A command whose bit 6 is 0 loads the pointer from bits 5..0. A command whose bits 6..3 are 1100 loads the bank counter from bits 2..0. The next data byte uses the loaded value. Pointer and bank counter are 0 after reset.
- R8: An acknowledge pulls SDA low (`sda_pull_o` = 1) from the SCL falling edge after the eighth data bit until the following SCL falling edge. At all other times SDA is released.
- R9: During and after reset, `sda_pull_o`, `cmd_valid_o` and `ram_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| bus_sel_i | input | 1 | Strap pin compared with address bit 1 |
| dev_id_i | input | 3 | Hardwired cascade identity |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 7 | Low seven bits of the command byte |
| ram_we_o | output | 1 | Display RAM write strobe |
| ram_addr_o | output | 6 | Display RAM write address |
| ram_wdata_o | output | 8 | Display RAM write data |

## Verification
The hardest situation to reach is the pointer wrap that moves the bank counter onto this device's identity in the middle of a data run. Before the wrap the device must stay silent and still count; right after it, the device must begin acknowledging and writing at address 0. The stimulus first loads the pointer near its top value with the bank set to a different identity, then streams data bytes across the wrap. A repeated START inside a data run, followed by a bank load that deselects the device, shows that matching restarts and that the new bank value takes effect.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
  // Parser phases; PH_SKIP is both the idle state and the deselected state.
  typedef enum logic [1:0] {
    PH_SKIP = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  // Fixed upper six bits of the address byte.
  localparam logic [5:0] ADDR_STEM = 6'b011111;
  // Command bits 6..3 that select a bank counter load.
  localparam logic [3:0] BANK_OPC  = 4'b1100;
endpackage

// File: rtl/lcdrx_sync.sv
// Synchronises the two bus lines and derives edge and condition pulses.
module lcdrx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic          scl_q, sda_q;
  logic [LAST:0] scl_pipe_n, sda_pipe_n;
  logic          scl_lvl;

  always_comb begin
    scl_pipe_n = {scl_pipe[LAST-1:0], scl_i};
    sda_pipe_n = {sda_pipe[LAST-1:0], sda_i};
  end

  // Idle bus lines are high, so reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
      scl_q    <= scl_pipe[LAST];
      sda_q    <= sda_pipe[LAST];
    end
  end

  assign scl_lvl   = scl_pipe[LAST];
  assign sda_lvl   = sda_pipe[LAST];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/lcdrx_bytes.sv
// Bit counter, shift register and acknowledge slot driver.
module lcdrx_bytes (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       ack_req,
  output logic [7:0] byte_q,
  output logic       byte_done,
  output logic [3:0] bit_cnt,
  output logic       sda_pull
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [7:0] shreg, shreg_n;
  logic [3:0] cnt, cnt_n;
  logic       done, done_n;
  logic       in_ack, in_ack_n;
  logic       pull, pull_n;

  always_comb begin
    shreg_n  = shreg;
    cnt_n    = cnt;
    done_n   = 1'b0;
    in_ack_n = in_ack;
    pull_n   = pull;
    if (start_det || stop_det) begin
      cnt_n    = '0;
      in_ack_n = 1'b0;
      pull_n   = 1'b0;
    end else if (scl_rise && (cnt < ACK_SLOT)) begin
      shreg_n = {shreg[6:0], sda_lvl};
      cnt_n   = cnt + 4'd1;
      done_n  = (cnt == 4'd7);
    end else if (scl_fall && (cnt == ACK_SLOT)) begin
      if (!in_ack) begin
        // Falling edge after the eighth bit opens the slot.
        in_ack_n = 1'b1;
        pull_n   = ack_req;
      end else begin
        // Falling edge after the ninth clock closes it.
        in_ack_n = 1'b0;
        pull_n   = 1'b0;
        cnt_n    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      in_ack <= 1'b0;
      pull   <= 1'b0;
    end else begin
      shreg  <= shreg_n;
      cnt    <= cnt_n;
      done   <= done_n;
      in_ack <= in_ack_n;
      pull   <= pull_n;
    end
  end

  assign byte_q    = shreg;
  assign byte_done = done;
  assign bit_cnt   = cnt;
  assign sda_pull  = pull;
endmodule

// File: rtl/lcdrx_parse.sv
// Byte-level parser: address match, command run, data placement.
module lcdrx_parse
  import lcdrx_pkg::*;
#(
  parameter int PTR_W = 6,   // at most 6: loaded from command bits 5..0
  parameter int ID_W  = 3    // at most 3: loaded from command bits 2..0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             byte_done,
  input  logic [7:0]       byte_q,
  input  logic             bus_sel,
  input  logic [ID_W-1:0]  dev_id,
  output logic             ack_req,
  output logic             cmd_valid,
  output logic [6:0]       cmd_data,
  output logic             ram_we,
  output logic [PTR_W-1:0] ram_addr,
  output logic [7:0]       ram_wdata,
  output phase_t           phase
);
  localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

  phase_t           ph, ph_n;
  logic [PTR_W-1:0] ptr, ptr_n, wa, wa_n;
  logic [ID_W-1:0]  bank, bank_n;
  logic             ack, ack_n, cv, cv_n, we, we_n;
  logic [6:0]       cd, cd_n;
  logic [7:0]       wd, wd_n;
  logic             addr_hit, bank_hit;

  assign addr_hit = (byte_q[7:1] == {ADDR_STEM, bus_sel}) && !byte_q[0];
  assign bank_hit = (bank == dev_id);

  always_comb begin
    ph_n   = ph;
    ptr_n  = ptr;
    bank_n = bank;
    ack_n  = ack;
    cv_n   = 1'b0;
    cd_n   = cd;
    we_n   = 1'b0;
    wa_n   = wa;
    wd_n   = wd;
    if (start_det || stop_det) begin
      ph_n  = PH_ADDR;
      ack_n = 1'b0;
    end else if (byte_done) begin
      ack_n = 1'b0;
      case (ph)
        PH_ADDR: begin
          ph_n  = addr_hit ? PH_CMD : PH_SKIP;
          ack_n = addr_hit;
        end
        PH_CMD: begin
          ack_n = 1'b1;
          cv_n  = 1'b1;
          cd_n  = byte_q[6:0];
          if (!byte_q[6]) begin
            ptr_n = byte_q[PTR_W-1:0];
          end else if (byte_q[6:3] == BANK_OPC) begin
            bank_n = byte_q[ID_W-1:0];
          end
          ph_n = byte_q[7] ? PH_CMD : PH_DATA;
        end
        PH_DATA: begin
          ack_n = bank_hit;
          we_n  = bank_hit;
          wa_n  = ptr;
          wd_n  = byte_q;
          ptr_n = ptr + PTR_W'(1);
          if (ptr == PTR_MAX) begin
            bank_n = bank + ID_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_SKIP;
      ptr  <= '0;
      bank <= '0;
      ack  <= 1'b0;
      cv   <= 1'b0;
      cd   <= '0;
      we   <= 1'b0;
      wa   <= '0;
      wd   <= '0;
    end else begin
      ph   <= ph_n;
      ptr  <= ptr_n;
      bank <= bank_n;
      ack  <= ack_n;
      cv   <= cv_n;
      cd   <= cd_n;
      we   <= we_n;
      wa   <= wa_n;
      wd   <= wd_n;
    end
  end

  assign ack_req   = ack;
  assign cmd_valid = cv;
  assign cmd_data  = cd;
  assign ram_we    = we;
  assign ram_addr  = wa;
  assign ram_wdata = wd;
  assign phase     = ph;
endmodule

// File: rtl/lcdrx_top.sv
module lcdrx_top
  import lcdrx_pkg::*;
#(
  parameter int PTR_W       = 6,
  parameter int ID_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             bus_sel_i,
  input  logic [ID_W-1:0]  dev_id_i,
  output logic             sda_pull_o,
  output logic             cmd_valid_o,
  output logic [6:0]       cmd_o,
  output logic             ram_we_o,
  output logic [PTR_W-1:0] ram_addr_o,
  output logic [7:0]       ram_wdata_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  logic       scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic [7:0] byte_q;
  logic       byte_done, ack_req;
  logic [3:0] bit_cnt;
  phase_t     phase;

  lcdrx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  lcdrx_bytes u_bytes (
    .clk       (clk),
    .rst_n     (rst_core),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .ack_req   (ack_req),
    .byte_q    (byte_q),
    .byte_done (byte_done),
    .bit_cnt   (bit_cnt),
    .sda_pull  (sda_pull_o)
  );

  lcdrx_parse #(.PTR_W(PTR_W), .ID_W(ID_W)) u_parse (
    .clk       (clk),
    .rst_n     (rst_core),
    .start_det (start_det),
    .stop_det  (stop_det),
    .byte_done (byte_done),
    .byte_q    (byte_q),
    .bus_sel   (bus_sel_i),
    .dev_id    (dev_id_i),
    .ack_req   (ack_req),
    .cmd_valid (cmd_valid_o),
    .cmd_data  (cmd_o),
    .ram_we    (ram_we_o),
    .ram_addr  (ram_addr_o),
    .ram_wdata (ram_wdata_o),
    .phase     (phase)
  );
endmodule

// File: rtl/lcdrx_chk.sv
module lcdrx_chk
  import lcdrx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       cmd_valid,
  input logic       ram_we,
  input logic       byte_done,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic [3:0] bit_cnt,
  input phase_t     phase
);
  p_cmd_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_cmd_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(byte_done));

  p_we_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(byte_done) && ($past(phase) == PH_DATA)));

  p_cmd_or_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && ram_we));

  p_pull_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (bit_cnt == 4'd8));

  p_pull_moves_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_det || stop_det));

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!sda_pull && !ram_we && !cmd_valid));
endmodule

bind lcdrx_top lcdrx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core),
  .sda_pull  (sda_pull_o),
  .cmd_valid (cmd_valid_o),
  .ram_we    (ram_we_o),
  .byte_done (byte_done),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .bit_cnt   (bit_cnt),
  .phase     (phase)
);

// File: tb/lcdrx_top_tb.sv
module lcdrx_top_tb;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       scl_m, sda_m, bus_sel;
  logic [2:0] dev_id;
  logic       sda_pull, cmd_valid, ram_we;
  logic [6:0] cmd;
  logic [5:0] ram_addr;
  logic [7:0] ram_wdata;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  lcdrx_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .bus_sel_i   (bus_sel),
    .dev_id_i    (dev_id),
    .sda_pull_o  (sda_pull),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata)
  );

  int checks = 0;
  int fails  = 0;
  bit live   = 1'b0;

  // Behavioural model state: 0 skip, 1 address, 2 command, 3 data.
  int m_phase = 0;
  int m_ptr   = 0;
  int m_bank  = 0;
  int exp_cmd[$];
  int exp_wr[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare strobes against expected events on every clock.
  always @(negedge clk) begin
    if (live) begin
      if (cmd_valid) begin
        if (exp_cmd.size() == 0) chk(1'b0, "R3 unexpected command strobe", int'(cmd), -1);
        else begin
          int e;
          e = exp_cmd.pop_front();
          chk(int'(cmd) == e, "R3 command value", int'(cmd), e);
        end
      end
      if (ram_we) begin
        if (exp_wr.size() == 0) chk(1'b0, "R5 unexpected write", {ram_addr, ram_wdata}, -1);
        else begin
          int e;
          e = exp_wr.pop_front();
          chk(int'({ram_addr, ram_wdata}) == e, "R5 R6 write address/data", int'({ram_addr, ram_wdata}), e);
        end
      end
    end
  end

  task automatic half_wait();
    repeat (HALF) @(posedge clk);
  endtask

  // Model one received byte; returns expected acknowledge.
  task automatic model_byte(input logic [7:0] b, output bit ack, output string tag);
    ack = 1'b0;
    tag = "R2 ignored byte";
    case (m_phase)
      1: begin
        tag = "R2 address ack";
        if (b[7:2] == 6'b011111 && b[1] == bus_sel && !b[0]) begin
          ack = 1'b1; m_phase = 2;
        end else m_phase = 0;
      end
      2: begin
        tag = "R3 command ack";
        ack = 1'b1;
        exp_cmd.push_back(int'(b[6:0]));
        if (!b[6]) m_ptr = int'(b[5:0]);                 // R7 pointer load
        else if (b[6:3] == 4'b1100) m_bank = int'(b[2:0]); // R7 bank load
        m_phase = b[7] ? 2 : 3;                            // R4 continuation
      end
      3: begin
        tag = "R5 data ack";
        ack = (m_bank == int'(dev_id));
        if (ack) exp_wr.push_back(m_ptr * 256 + int'(b));
        if (m_ptr == 63) begin
          m_ptr = 0; m_bank = (m_bank + 1) % 8;            // R6 wrap
        end else m_ptr = m_ptr + 1;
      end
      default: ;
    endcase
  endtask

  task automatic bus_start();   // R1 START or repeated START
    sda_m = 1'b1; half_wait();
    scl_m = 1'b1; half_wait();
    sda_m = 1'b0; half_wait();
    scl_m = 1'b0; half_wait();
    m_phase = 1;
  endtask

  task automatic bus_stop();    // R1 STOP
    sda_m = 1'b0; half_wait();
    scl_m = 1'b1; half_wait();
    sda_m = 1'b1; half_wait();
    m_phase = 1;
  endtask

  task automatic send(input logic [7:0] b);
    bit    ack;
    string tag;
    model_byte(b, ack, tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half_wait();
      scl_m = 1'b1;
      repeat (HALF / 2) @(posedge clk);
      @(negedge clk);
      chk(sda_pull == 1'b0, "R8 released during data bit", int'(sda_pull), 0);
      repeat (HALF / 2) @(posedge clk);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; half_wait();
    scl_m = 1'b1;
    repeat (HALF / 2) @(posedge clk);
    @(negedge clk);
    chk(sda_pull == ack, {tag, " R8 slot"}, int'(sda_pull), int'(ack));
    repeat (HALF / 2) @(posedge clk);
    scl_m = 1'b0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; bus_sel = 1'b0; dev_id = 3'd0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(!sda_pull && !cmd_valid && !ram_we, "R9 outputs in reset",
        {sda_pull, cmd_valid, ram_we}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!sda_pull && !cmd_valid && !ram_we, "R9 outputs after reset",
        {sda_pull, cmd_valid, ram_we}, 0);
    live = 1'b1;

    // R7 pointer then bank load via a continued command run (R4), data to id 0.
    bus_start();
    send(8'h7C); send(8'h85); send(8'h60);
    send(8'hA1); send(8'hB2);
    bus_stop();

    // R6 wrap: id 1 silent at 62 and 63, then bank steps to 1 and writes start at 0.
    dev_id = 3'd1;
    bus_start();
    send(8'h7C); send(8'h3E);
    send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    bus_stop();

    // R2 strap mismatch and read request ignored; R1 repeated START recovers.
    bus_start();
    send(8'h7E); send(8'h80); send(8'h11);
    bus_start();
    send(8'h7D); send(8'h22);
    bus_start();
    send(8'h7C); send(8'h61); send(8'h55);
    bus_stop();

    // R1 repeated START inside data; R7 bank load deselects id 1 (R5 no ack).
    bus_start();
    send(8'h7C); send(8'h07); send(8'h33);
    bus_start();
    send(8'h7C); send(8'h84); send(8'h62); send(8'h99); send(8'h98);
    bus_stop();

    // R2 strap high device; R3 command ack independent of id; R5 write at 16.
    bus_sel = 1'b1; dev_id = 3'd2;
    bus_start();
    send(8'h7E); send(8'h90); send(8'h10); send(8'h42);
    bus_stop();

    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(exp_cmd.size() == 0, "R3 all commands seen", exp_cmd.size(), 0);
    chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
    summary();
    $finish;
  end
endmodule